// File: doc/BRIEF.md
# Multi-Queue Shared-Memory FIFO Controller

This block divides a single data memory into as many as `MAX_Q` independent logical FIFO queues. One write port and one read port each carry a queue number next to their data. On the write side that number steers the incoming word into the chosen queue. On the read side it selects which queue supplies the next output word. The two ports are fully independent. In the same clock cycle they may address different queues or the same queue, and each port can transfer one word on every cycle.

Each queue is described by a record held in registers. The record gives the queue's base slot in the shared memory, its depth, a read pointer, a write pointer, an occupancy count, an almost-full threshold and an almost-empty threshold. After reset every queue receives an equal slice of the memory with default thresholds. A small configuration interface can then rewrite any queue's record and the number of active queues.

The status outputs follow the queue addressed on each port. The full and almost-full flags describe the queue last selected on the write side. The empty and almost-empty flags describe the queue last selected on the read side.

Top module: `mq_fifo`

## Requirements
- R1: After reset, the active queue count is `MAX_Q` and every queue is empty. Queue i starts at slot i*D and holds D = `MEM_DEPTH`/`MAX_Q` words (16 with the default parameters). Its almost-full threshold is D-2 and its almost-empty threshold is 2. `rd_valid` is 0.
- R2: Words written to a queue are read back from that queue in the order they were written. A read accepted at a clock edge puts its word on `rd_data` with `rd_valid`=1 after that edge. After any edge with no accepted read, `rd_valid` is 0.
- R3: A write to a queue whose count equals its depth is ignored: the word is not stored and the count does not change. This holds even when the same queue is read in the same cycle.
- R4: A read from a queue whose count is 0 is ignored and `rd_valid` stays 0. This holds even when the same queue is written in the same cycle.
- R5: After each edge, `full` is 1 exactly when the count of queue `wr_q` (as sampled at that edge) equals its depth. The count used includes any transfers made at that edge.
- R6: After each edge, `empty` is 1 exactly when the count of queue `rd_q` (as sampled at that edge) is 0. The count used includes any transfers made at that edge.
- R7: `almost_full` is 1 when the count of the write-selected queue is at least its almost-full threshold. `almost_empty` is 1 when the count of the read-selected queue is at most its almost-empty threshold. Both use the same selection timing as R5 and R6.
- R8: When an accepted read and an accepted write hit the same queue in one cycle, both words transfer and the count stays unchanged. Such transfers can continue on every cycle.
- R9: A cycle with `cfg_we`=1 loads the record of queue `cfg_qid` with `cfg_base`, `cfg_depth`, `cfg_afull` and `cfg_aempty`, and empties that queue. A `cfg_depth` of 0 or above `MEM_DEPTH` makes the load ignored.
- R10: A cycle with `cfg_nq_we`=1 sets the active queue count to `cfg_nq` if the value is between 1 and `MAX_Q`; other values are ignored. Reads and writes to a queue number at or above the count are ignored. While such a queue is selected, all four flags read 1.
- R11: A write to one queue and a read from a different queue in the same cycle both take effect without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one queue record |
| cfg_qid | input | $clog2(MAX_Q) | Queue whose record is loaded |
| cfg_base | input | $clog2(MEM_DEPTH) | First memory slot of the queue |
| cfg_depth | input | $clog2(MEM_DEPTH)+1 | Queue capacity in words |
| cfg_afull | input | $clog2(MEM_DEPTH)+1 | Almost-full threshold |
| cfg_aempty | input | $clog2(MEM_DEPTH)+1 | Almost-empty threshold |
| cfg_nq_we | input | 1 | Load active queue count |
| cfg_nq | input | $clog2(MAX_Q+1) | New active queue count |
| wr_en | input | 1 | Write request |
| wr_q | input | $clog2(MAX_Q) | Write queue select |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_q | input | $clog2(MAX_Q) | Read queue select |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | rd_data carries a word read at the last edge |
| full | output | 1 | Write-selected queue is full |
| almost_full | output | 1 | Write-selected queue is at or above its threshold |
| empty | output | 1 | Read-selected queue is empty |
| almost_empty | output | 1 | Read-selected queue is at or below its threshold |

## Verification
The hardest case to reach from the ports is a full queue that receives a write and a read in the same cycle. In that cycle the read must succeed and the write must be dropped, and afterwards the dropped word must never reach the output. To get there, the stimulus fills one queue to exactly its depth, offers two more writes, and then offers a combined read and write. Draining the queue then shows that only the original sixteen words come out. The scoreboard also records whether each read is accepted, so a read of an empty queue that is combined with a write to the same queue is checked in the same way. The scoreboard compares every cycle's valid strobe and all four flags as well as the data.

// File: rtl/mq_pkg.sv
package mq_pkg;

  typedef struct packed {
    logic full;
    logic almost_full;
    logic empty;
    logic almost_empty;
  } mq_flags_t;

  // Offset of the next slot inside a ring of 'depth' entries.
  function automatic logic [31:0] ring_next(input logic [31:0] off, input logic [31:0] depth);
    return (off + 32'd1 == depth) ? 32'd0 : off + 32'd1;
  endfunction

  // Physical memory slot for a queue offset.
  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [31:0] off);
    return base + off;
  endfunction

  // Occupancy after one edge given accepted push / pop.
  function automatic logic [31:0] occ_next(input logic [31:0] cnt, input logic push, input logic pop);
    if (push && !pop) return cnt + 32'd1;
    if (pop && !push) return cnt - 32'd1;
    return cnt;
  endfunction

  function automatic logic at_least(input logic [31:0] cnt, input logic [31:0] thr);
    return cnt >= thr;
  endfunction

endpackage

// File: rtl/mq_qstate.sv
module mq_qstate
  import mq_pkg::*;
#(
  parameter int MAX_Q     = 32,
  parameter int MEM_DEPTH = 512,
  localparam int AW   = $clog2(MEM_DEPTH),
  localparam int CW   = AW + 1,
  localparam int QA_W = $clog2(MAX_Q),
  localparam int NQW  = $clog2(MAX_Q + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [QA_W-1:0] cfg_qid,
  input  logic [AW-1:0]   cfg_base,
  input  logic [CW-1:0]   cfg_depth,
  input  logic [CW-1:0]   cfg_afull,
  input  logic [CW-1:0]   cfg_aempty,
  input  logic            cfg_nq_we,
  input  logic [NQW-1:0]  cfg_nq,
  input  logic            wr_en,
  input  logic [QA_W-1:0] wr_q,
  input  logic            rd_en,
  input  logic [QA_W-1:0] rd_q,
  output logic            wr_go,
  output logic [AW-1:0]   wr_addr,
  output logic            rd_go,
  output logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   w_cnt,
  output logic [CW-1:0]   w_depth,
  output logic [CW-1:0]   w_afthr,
  output logic            w_act,
  output logic [CW-1:0]   r_cnt,
  output logic [CW-1:0]   r_aethr,
  output logic            r_act
);

  localparam int DEF_D = MEM_DEPTH / MAX_Q;

  logic [AW-1:0] base_q  [MAX_Q];
  logic [CW-1:0] depth_q [MAX_Q];
  logic [CW-1:0] cnt_q   [MAX_Q];
  logic [CW-1:0] afthr_q [MAX_Q];
  logic [CW-1:0] aethr_q [MAX_Q];
  logic [AW-1:0] wp_q    [MAX_Q];
  logic [AW-1:0] rp_q    [MAX_Q];
  logic [NQW-1:0]  nq_r;
  logic [QA_W-1:0] wsel_r, rsel_r;

  // Named internal events
  logic          cfg_ok, cfg_hit_w, cfg_hit_r;
  logic          w_act_now, r_act_now;
  logic [CW-1:0] w_cnt_now, r_cnt_now;
  logic          w_full_now, same_q, wr_drop, rd_drop;

  always_comb begin
    cfg_ok     = cfg_we && (cfg_depth != '0) && (cfg_depth <= CW'(MEM_DEPTH));
    cfg_hit_w  = cfg_ok && (cfg_qid == wr_q);
    cfg_hit_r  = cfg_ok && (cfg_qid == rd_q);
    w_act_now  = NQW'(wr_q) < nq_r;
    r_act_now  = NQW'(rd_q) < nq_r;
    w_cnt_now  = cnt_q[wr_q];
    r_cnt_now  = cnt_q[rd_q];
    w_full_now = (w_cnt_now == depth_q[wr_q]);
    same_q     = (wr_q == rd_q);
    wr_go      = wr_en && w_act_now && !w_full_now && !cfg_hit_w;
    rd_go      = rd_en && r_act_now && (r_cnt_now != '0) && !cfg_hit_r;
    wr_drop    = wr_en && !wr_go;
    rd_drop    = rd_en && !rd_go;
    wr_addr    = AW'(slot_addr(32'(base_q[wr_q]), 32'(wp_q[wr_q])));
    rd_addr    = AW'(slot_addr(32'(base_q[rd_q]), 32'(rp_q[rd_q])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nq_r   <= NQW'(MAX_Q);
      wsel_r <= '0;
      rsel_r <= '0;
      for (int i = 0; i < MAX_Q; i++) begin
        base_q[i]  <= AW'(i * DEF_D);
        depth_q[i] <= CW'(DEF_D);
        cnt_q[i]   <= '0;
        afthr_q[i] <= CW'(DEF_D - 2);
        aethr_q[i] <= CW'(2);
        wp_q[i]    <= '0;
        rp_q[i]    <= '0;
      end
    end else begin
      wsel_r <= wr_q;
      rsel_r <= rd_q;
      if (cfg_nq_we && (cfg_nq != '0) && (cfg_nq <= NQW'(MAX_Q)))
        nq_r <= cfg_nq;
      for (int i = 0; i < MAX_Q; i++) begin
        if (cfg_ok && (cfg_qid == QA_W'(i))) begin
          base_q[i]  <= cfg_base;
          depth_q[i] <= cfg_depth;
          afthr_q[i] <= cfg_afull;
          aethr_q[i] <= cfg_aempty;
          cnt_q[i]   <= '0;
          wp_q[i]    <= '0;
          rp_q[i]    <= '0;
        end else begin
          if (wr_go && (wr_q == QA_W'(i)))
            wp_q[i] <= AW'(ring_next(32'(wp_q[i]), 32'(depth_q[i])));
          if (rd_go && (rd_q == QA_W'(i)))
            rp_q[i] <= AW'(ring_next(32'(rp_q[i]), 32'(depth_q[i])));
          cnt_q[i] <= CW'(occ_next(32'(cnt_q[i]),
                                   wr_go && (wr_q == QA_W'(i)),
                                   rd_go && (rd_q == QA_W'(i))));
        end
      end
    end
  end

  always_comb begin
    w_cnt   = cnt_q[wsel_r];
    w_depth = depth_q[wsel_r];
    w_afthr = afthr_q[wsel_r];
    w_act   = NQW'(wsel_r) < nq_r;
    r_cnt   = cnt_q[rsel_r];
    r_aethr = aethr_q[rsel_r];
    r_act   = NQW'(rsel_r) < nq_r;
  end

  // R3: occupancy of the write-selected queue never exceeds its depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_cnt <= w_depth);

  // R3: a dropped write leaves its queue's count alone
  assert_drop_write_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !(rd_go && same_q) && !cfg_hit_w) |=> (w_cnt == $past(w_cnt_now)));

  // R4: a dropped read leaves its queue's count alone
  assert_drop_read_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drop && !(wr_go && same_q) && !cfg_hit_r) |=> (r_cnt == $past(r_cnt_now)));

  // R8: push and pop on one queue in one cycle keep the count
  assert_same_queue_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_go && same_q) |=> (w_cnt == $past(w_cnt_now)));

endmodule

// File: rtl/mq_store.sv
module mq_store #(
  parameter int DATA_W    = 18,
  parameter int MEM_DEPTH = 512,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] mem [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= mem[rd_addr];
    end
  end

  // R8: a read and a write in the same cycle never touch the same slot
  assert_no_slot_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_go) |-> (wr_addr != rd_addr));

  // R2: an accepted read yields a valid word after the edge
  assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);

  // R4: no accepted read, no valid strobe
  assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rd_valid);

endmodule

// File: rtl/mq_flags.sv
module mq_flags
  import mq_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic [CW-1:0] w_cnt,
  input  logic [CW-1:0] w_depth,
  input  logic [CW-1:0] w_afthr,
  input  logic          w_act,
  input  logic [CW-1:0] r_cnt,
  input  logic [CW-1:0] r_aethr,
  input  logic          r_act,
  output mq_flags_t     flags
);

  always_comb begin
    flags.full         = !w_act || (w_cnt == w_depth);
    flags.almost_full  = !w_act || at_least(32'(w_cnt), 32'(w_afthr));
    flags.empty        = !r_act || (r_cnt == '0);
    flags.almost_empty = !r_act || at_least(32'(r_aethr), 32'(r_cnt));
    // R10: an inactive selection reports every flag set
    assert_inactive_flags_R10: assert (w_act || (flags.full && flags.almost_full));
  end

endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
  import mq_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int MAX_Q     = 32,
  parameter int MEM_DEPTH = 512,
  localparam int AW   = $clog2(MEM_DEPTH),
  localparam int CW   = AW + 1,
  localparam int QA_W = $clog2(MAX_Q),
  localparam int NQW  = $clog2(MAX_Q + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [QA_W-1:0]   cfg_qid,
  input  logic [AW-1:0]     cfg_base,
  input  logic [CW-1:0]     cfg_depth,
  input  logic [CW-1:0]     cfg_afull,
  input  logic [CW-1:0]     cfg_aempty,
  input  logic              cfg_nq_we,
  input  logic [NQW-1:0]    cfg_nq,
  input  logic              wr_en,
  input  logic [QA_W-1:0]   wr_q,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [QA_W-1:0]   rd_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              almost_full,
  output logic              empty,
  output logic              almost_empty
);

  logic          wr_go, rd_go, w_act, r_act;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] w_cnt, w_depth, w_afthr, r_cnt, r_aethr;
  mq_flags_t     flags;

  mq_qstate #(.MAX_Q(MAX_Q), .MEM_DEPTH(MEM_DEPTH)) u_state (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
    .cfg_afull(cfg_afull), .cfg_aempty(cfg_aempty),
    .cfg_nq_we(cfg_nq_we), .cfg_nq(cfg_nq),
    .wr_en(wr_en), .wr_q(wr_q), .rd_en(rd_en), .rd_q(rd_q),
    .wr_go(wr_go), .wr_addr(wr_addr), .rd_go(rd_go), .rd_addr(rd_addr),
    .w_cnt(w_cnt), .w_depth(w_depth), .w_afthr(w_afthr), .w_act(w_act),
    .r_cnt(r_cnt), .r_aethr(r_aethr), .r_act(r_act)
  );

  mq_store #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_go(rd_go), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  mq_flags #(.CW(CW)) u_flags (
    .w_cnt(w_cnt), .w_depth(w_depth), .w_afthr(w_afthr), .w_act(w_act),
    .r_cnt(r_cnt), .r_aethr(r_aethr), .r_act(r_act),
    .flags(flags)
  );

  assign full         = flags.full;
  assign almost_full  = flags.almost_full;
  assign empty        = flags.empty;
  assign almost_empty = flags.almost_empty;

  // R6: an empty read-side queue cannot produce data at the next edge
  assert_empty_blocks_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && (rd_q == $past(rd_q)) && !cfg_we) |=> !rd_valid);

endmodule

// File: tb/mq_fifo_test.sv
module mq_fifo_test;

  localparam int DW = 18;
  localparam int NQ = 32;
  localparam int MD = 512;
  localparam int DD = MD / NQ;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_qid = '0;
  logic [8:0]    cfg_base = '0;
  logic [9:0]    cfg_depth = '0, cfg_afull = '0, cfg_aempty = '0;
  logic          cfg_nq_we = 1'b0;
  logic [5:0]    cfg_nq = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]    wr_q = '0, rd_q = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, full, almost_full, empty, almost_empty;

  always #4 clk = ~clk;  // 125 MHz

  mq_fifo #(.DATA_W(DW), .MAX_Q(NQ), .MEM_DEPTH(MD)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
    .cfg_afull(cfg_afull), .cfg_aempty(cfg_aempty),
    .cfg_nq_we(cfg_nq_we), .cfg_nq(cfg_nq),
    .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .rd_en(rd_en), .rd_q(rd_q),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .full(full), .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty)
  );

  // Reference model
  logic [DW-1:0] model_q [NQ][$];
  int m_depth [NQ];
  int m_af [NQ];
  int m_ae [NQ];
  int m_nq = NQ;
  int cur_wq = 0, cur_rq = 0;

  // Scoreboard expectations for the next edge
  logic [DW-1:0] exp_q [$];
  bit    exp_rv = 0;
  bit    e_full = 0, e_af = 0, e_empty = 1, e_ae = 1;
  string tag = "R1";
  bit    mon_on = 0;
  int    n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void set_flags();
    bit wa = cur_wq < m_nq;
    bit ra = cur_rq < m_nq;
    int wn = model_q[cur_wq].size();
    int rn = model_q[cur_rq].size();
    e_full  = !wa || (wn == m_depth[cur_wq]);
    e_af    = !wa || (wn >= m_af[cur_wq]);
    e_empty = !ra || (rn == 0);
    e_ae    = !ra || (rn <= m_ae[cur_rq]);
  endfunction

  task automatic step(input bit we, input int wq, input int wd, input bit re, input int rq);
    bit wacc, racc;
    @(negedge clk);
    cfg_we = 1'b0; cfg_nq_we = 1'b0;
    wr_en = we; wr_q = 5'(wq); wr_data = DW'(wd);
    rd_en = re; rd_q = 5'(rq);
    cur_wq = wq; cur_rq = rq;
    wacc = we && (wq < m_nq) && (model_q[wq].size() < m_depth[wq]);
    racc = re && (rq < m_nq) && (model_q[rq].size() > 0);
    exp_rv = racc;
    if (racc) exp_q.push_back(model_q[rq].pop_front());
    if (wacc) model_q[wq].push_back(DW'(wd));
    set_flags();
  endtask

  task automatic cfg_queue(input int q, input int base, input int depth, input int af, input int ae);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; cfg_nq_we = 1'b0;
    cfg_we = 1'b1; cfg_qid = 5'(q); cfg_base = 9'(base);
    cfg_depth = 10'(depth); cfg_afull = 10'(af); cfg_aempty = 10'(ae);
    exp_rv = 0;
    if (depth != 0 && depth <= MD) begin
      m_depth[q] = depth; m_af[q] = af; m_ae[q] = ae;
      model_q[q].delete();
    end
    set_flags();
  endtask

  task automatic cfg_count(input int n);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; cfg_we = 1'b0;
    cfg_nq_we = 1'b1; cfg_nq = 6'(n);
    exp_rv = 0;
    if (n >= 1 && n <= NQ) m_nq = n;
    set_flags();
  endtask

  task automatic idle();
    step(0, cur_wq, 0, 0, cur_rq);
  endtask

  // Monitor: compares after each edge, away from the edge
  always @(posedge clk) begin
    if (mon_on) begin
      #2;
      check(rd_valid == exp_rv, "R2 rd_valid", rd_valid, exp_rv);
      if (rd_valid && exp_rv) begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R2 rd_data", rd_data, e);
      end
      check(full == e_full, "R5 full", full, e_full);
      check(empty == e_empty, "R6 empty", empty, e_empty);
      check(almost_full == e_af, "R7 almost_full", almost_full, e_af);
      check(almost_empty == e_ae, "R7 almost_empty", almost_empty, e_ae);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: got hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_depth[q] = DD; m_af[q] = DD - 2; m_ae[q] = 2;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    tag = "R1";
    check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    check(empty == 1, "R1 empty", empty, 1);
    check(full == 0, "R1 full", full, 0);
    check(almost_empty == 1, "R1 almost_empty", almost_empty, 1);
    set_flags();
    mon_on = 1;
    idle();

    // R2: interleaved queues keep per-queue order
    tag = "R2";
    for (int k = 0; k < 5; k++) begin
      step(1, 3, 100 + k, 0, 3);
      step(1, 7, 200 + k, 0, 7);
    end
    for (int k = 0; k < 5; k++) begin
      step(0, 7, 0, 1, 3);
      step(0, 7, 0, 1, 7);
    end
    idle();

    // R1 default depth of 16, R3 write to full queue dropped
    tag = "R1/R3";
    for (int k = 0; k < DD; k++) step(1, 5, 300 + k, 0, 5);
    step(1, 5, 999, 0, 5);
    step(1, 5, 998, 0, 5);
    step(1, 5, 777, 1, 5);
    for (int k = 0; k < DD; k++) step(0, 5, 0, 1, 5);
    idle();

    // R4: read of empty queue with same-cycle write is dropped
    tag = "R4";
    step(1, 9, 400, 1, 9);
    step(0, 9, 0, 1, 9);
    step(0, 9, 0, 1, 9);
    idle();

    // R8: back-to-back same-queue read and write
    tag = "R8";
    for (int k = 0; k < 4; k++) step(1, 2, 450 + k, 0, 2);
    for (int k = 0; k < 20; k++) step(1, 2, 500 + k, 1, 2);
    for (int k = 0; k < 4; k++) step(0, 2, 0, 1, 2);
    idle();

    // R11: different queues on the two ports
    tag = "R11";
    for (int k = 0; k < 3; k++) step(1, 4, 550 + k, 0, 4);
    for (int k = 0; k < 12; k++) step(1, 1, 600 + k, 1, 4);
    for (int k = 0; k < 12; k++) step(0, 4, 0, 1, 1);
    idle();

    // R9: record load with custom depth and thresholds; depth 0 ignored
    tag = "R9";
    cfg_queue(6, 96, 4, 3, 1);
    for (int k = 0; k < 5; k++) step(1, 6, 700 + k, 0, 6);
    for (int k = 0; k < 5; k++) step(0, 6, 0, 1, 6);
    cfg_queue(6, 96, 0, 9, 9);
    for (int k = 0; k < 5; k++) step(1, 6, 720 + k, 0, 6);
    for (int k = 0; k < 4; k++) step(0, 6, 0, 1, 6);
    idle();

    // R10: active queue count gating and invalid counts
    tag = "R10";
    cfg_count(4);
    step(1, 10, 800, 1, 10);
    step(1, 2, 801, 0, 10);
    cfg_count(0);
    step(1, 10, 802, 1, 2);
    cfg_count(NQ);
    step(0, 10, 0, 1, 10);
    idle();
    idle();

    mon_on = 0;
    check(exp_q.size() == 0, "R2 pending reads", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule